// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Masking and Entry Latency

The block gathers level-style request lines from a set of peripherals, together with one separate urgent line that reacts to a rising edge and cannot be masked. Each request is latched into a pending bit. A pending line may raise the interrupt output only if its mask bit is clear and the global enable flag is set. The urgent line bypasses both of these controls. When several requests are eligible, the lowest-numbered line wins and the urgent line beats all of them. The controller raises `int_o` and reports the winning number on `id_o`.

The processor accepts the interrupt with a one-cycle `ack_i`. From then on the controller models a fixed entry delay. After that delay it pulses `vec_valid_o` for one cycle, with the service address taken from a vector table indexed by the winning number. While a maskable routine is in service, no other maskable request is signalled, but the urgent line may still preempt it. While an urgent routine is in service, nothing is signalled. An `eos_i` pulse ends the innermost routine in service.

Software writes the mask, the enable flag and the vector entries through one register port. Address 0 holds the mask, address 1 holds the enable flag, and addresses 2 to 2+N_LINES hold the vector entries.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Among the eligible maskable lines, the lowest index wins. The urgent line is reported as id N_LINES (8 by default) and beats every maskable line.
- R2: Writing address 0 sets the mask: wdata bit i = 1 blocks line i. A blocked line stays pending and is signalled once its mask bit is cleared.
- R3: Address 1 bit 0 is the global enable. While it is 0, no maskable line is signalled. Requests that arrived in that time stay pending.
- R4: A rising edge on `nmi_i` raises the interrupt with id N_LINES whatever the mask and enable hold. Keeping `nmi_i` high does not raise it again.
- R5: A request that is high at clock edge j makes `int_o` high, with the winner on `id_o`, after edge j+1.
- R6: An `ack_i` sampled while `int_o` is high drops `int_o` at that edge and clears the pending bit of the acknowledged line.
- R7: `vec_valid_o` is high for exactly one cycle, ENTRY_LAT (5) edges after the acknowledge edge. While it is high, `vec_o` holds the table entry written at address 2+id and `id_o` holds the acknowledged id.
- R8: While a maskable routine is in service, no maskable interrupt is signalled, but the urgent line may preempt. While an urgent routine is in service, no interrupt at all is signalled.
- R9: `eos_i` ends the innermost routine in service. If an eligible request is still pending, `int_o` goes high one edge after the edge that sampled `eos_i`.
- R10: After reset, `int_o`, `vec_valid_o`, `id_o` and `vec_o` are 0, the mask is all clear and the global enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | N_LINES | Maskable request lines, latched while high |
| nmi_i | input | 1 | Urgent request, rising-edge sensitive |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register address: 0 mask, 1 enable, 2+k vector k |
| cfg_wdata | input | 32 | Register write data |
| ack_i | input | 1 | Processor accepts the signalled interrupt |
| eos_i | input | 1 | End of the current service routine |
| int_o | output | 1 | Interrupt request to the processor |
| id_o | output | IDW | Number of the signalled or accepted request |
| vec_valid_o | output | 1 | One-cycle strobe: vector is ready |
| vec_o | output | 32 | Service routine address |

## Verification
The properties assume that `ack_i` arrives only while `int_o` is high and that `eos_i` arrives only while a routine is in service. They also assume that `ack_i` and `eos_i` are never asserted in the same cycle. The stimulus follows these rules: every acknowledge comes from a task that first checks `int_o`, and every end-of-service pulse is given only after the vector has appeared. Maskable requests are driven as one-cycle pulses, so an acknowledged line is not latched again by a request that is still held high. The urgent line is held high across whole phases, to show that a steady level does not raise it again.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    SEQ_ARB = 1'b0,
    SEQ_LAT = 1'b1
  } seq_st_e;

  localparam int VEC_DW   = 32;
  localparam int VEC_BASE = 2;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               nmi_i,
  input  logic [N_LINES-1:0] clr_line,
  input  logic               clr_nmi,
  output logic [N_LINES-1:0] pend_o,
  output logic               nmi_pend_o
);
  logic nmi_q;

  // one pending flop per maskable line
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_o[i] <= 1'b0;
      end else if (clr_line[i]) begin
        pend_o[i] <= 1'b0;
      end else if (irq_i[i]) begin
        pend_o[i] <= 1'b1;
      end
    end
  end

  // urgent line: rising-edge capture
  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q      <= 1'b0;
      nmi_pend_o <= 1'b0;
    end else begin
      nmi_q <= nmi_i;
      if (clr_nmi) begin
        nmi_pend_o <= 1'b0;
      end else if (nmi_i && !nmi_q) begin
        nmi_pend_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N_LINES = 8,
  parameter int IDW     = $clog2(N_LINES + 1)
) (
  input  logic [N_LINES-1:0] elig_i,
  input  logic               nmi_elig_i,
  output logic               any_o,
  output logic [IDW-1:0]     win_o
);
  always_comb begin
    any_o = nmi_elig_i | (|elig_i);
    win_o = '0;
    // scan from the weakest line so the lowest index is left standing
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (elig_i[i]) win_o = IDW'(i);
    end
    if (nmi_elig_i) win_o = IDW'(N_LINES);
  end
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
  parameter int DEPTH = 9,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [0:DEPTH-1];

  // storage: plain write port, no reset, so block RAM can hold it
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
#(
  parameter int N_LINES   = 8,
  parameter int ENTRY_LAT = 5,
  parameter int IDW       = $clog2(N_LINES + 1),
  parameter int LCW       = $clog2(ENTRY_LAT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               any_i,
  input  logic [IDW-1:0]     win_i,
  input  logic               ack_i,
  input  logic               eos_i,
  output logic               int_o,
  output logic [IDW-1:0]     id_o,
  output logic               vec_valid_o,
  output logic               ms_busy_o,
  output logic               nmi_busy_o,
  output logic [N_LINES-1:0] clr_line_o,
  output logic               clr_nmi_o
);
  seq_st_e        st_q;
  logic [LCW-1:0] cnt_q;
  logic           take;
  logic           take_nmi;

  assign take     = (st_q == SEQ_ARB) && int_o && ack_i;
  assign take_nmi = (id_o == IDW'(N_LINES));
  assign clr_nmi_o = take && take_nmi;

  always_comb begin
    for (int i = 0; i < N_LINES; i++) begin
      clr_line_o[i] = take && (id_o == IDW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= SEQ_ARB;
      cnt_q       <= '0;
      int_o       <= 1'b0;
      id_o        <= '0;
      vec_valid_o <= 1'b0;
      ms_busy_o   <= 1'b0;
      nmi_busy_o  <= 1'b0;
    end else begin
      vec_valid_o <= 1'b0;

      // the innermost routine in service ends first
      if (eos_i) begin
        if (nmi_busy_o) nmi_busy_o <= 1'b0;
        else            ms_busy_o  <= 1'b0;
      end

      case (st_q)
        SEQ_ARB: begin
          if (take) begin
            int_o <= 1'b0;
            st_q  <= SEQ_LAT;
            cnt_q <= LCW'(ENTRY_LAT - 1);
            if (take_nmi) nmi_busy_o <= 1'b1;
            else          ms_busy_o  <= 1'b1;
          end else begin
            int_o <= any_i;
            if (any_i) id_o <= win_i;
          end
        end
        SEQ_LAT: begin
          if (cnt_q == '0) begin
            st_q        <= SEQ_ARB;
            vec_valid_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= SEQ_ARB;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_LINES   = 8,
  parameter int ENTRY_LAT = 5,
  parameter int IDW       = $clog2(N_LINES + 1),
  parameter int CFG_AW    = $clog2(N_LINES + VEC_BASE + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_LINES-1:0]   irq_i,
  input  logic                 nmi_i,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [VEC_DW-1:0]    cfg_wdata,
  input  logic                 ack_i,
  input  logic                 eos_i,
  output logic                 int_o,
  output logic [IDW-1:0]       id_o,
  output logic                 vec_valid_o,
  output logic [VEC_DW-1:0]    vec_o
);
  localparam int TBL_DEPTH = N_LINES + 1;

  logic [N_LINES-1:0] mask_q;
  logic               gie_q;
  logic [N_LINES-1:0] pend;
  logic               nmi_pend;
  logic [N_LINES-1:0] clr_line;
  logic               clr_nmi;
  logic               ms_busy;
  logic               nmi_busy;
  logic [N_LINES-1:0] elig;
  logic               nmi_elig;
  logic               any_win;
  logic [IDW-1:0]     win_id;
  logic               vec_we;
  logic [IDW-1:0]     vec_waddr;

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_AW'(0)) mask_q <= cfg_wdata[N_LINES-1:0];
      if (cfg_addr == CFG_AW'(1)) gie_q  <= cfg_wdata[0];
    end
  end

  assign vec_we    = cfg_we && (cfg_addr >= CFG_AW'(VEC_BASE))
                            && (cfg_addr <= CFG_AW'(VEC_BASE + N_LINES));
  assign vec_waddr = IDW'(cfg_addr - CFG_AW'(VEC_BASE));

  irq_pend #(.N_LINES(N_LINES)) u_pend (
    .clk        (clk),
    .rst        (rst),
    .irq_i      (irq_i),
    .nmi_i      (nmi_i),
    .clr_line   (clr_line),
    .clr_nmi    (clr_nmi),
    .pend_o     (pend),
    .nmi_pend_o (nmi_pend)
  );

  // gating: mask, global enable and in-service blocking
  assign elig     = pend & ~mask_q & {N_LINES{gie_q & ~ms_busy & ~nmi_busy}};
  assign nmi_elig = nmi_pend & ~nmi_busy;

  irq_prio #(.N_LINES(N_LINES), .IDW(IDW)) u_prio (
    .elig_i     (elig),
    .nmi_elig_i (nmi_elig),
    .any_o      (any_win),
    .win_o      (win_id)
  );

  irq_seq #(.N_LINES(N_LINES), .ENTRY_LAT(ENTRY_LAT), .IDW(IDW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .any_i       (any_win),
    .win_i       (win_id),
    .ack_i       (ack_i),
    .eos_i       (eos_i),
    .int_o       (int_o),
    .id_o        (id_o),
    .vec_valid_o (vec_valid_o),
    .ms_busy_o   (ms_busy),
    .nmi_busy_o  (nmi_busy),
    .clr_line_o  (clr_line),
    .clr_nmi_o   (clr_nmi)
  );

  irq_vec_table #(.DEPTH(TBL_DEPTH), .AW(IDW), .DW(VEC_DW)) u_tbl (
    .clk   (clk),
    .rst   (rst),
    .we    (vec_we),
    .waddr (vec_waddr),
    .wdata (cfg_wdata),
    .raddr (id_o),
    .rdata (vec_o)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N_LINES   = 8,
  parameter int ENTRY_LAT = 5,
  parameter int IDW       = $clog2(N_LINES + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               ack_i,
  input logic               int_o,
  input logic [IDW-1:0]     id_o,
  input logic               vec_valid_o,
  input logic [N_LINES-1:0] mask_q,
  input logic               gie_q,
  input logic               ms_busy,
  input logic               nmi_busy
);
  localparam int CW = $clog2(ENTRY_LAT + 2);

  logic [CW-1:0]    lat_cnt;
  logic [N_LINES:0] mask_d;
  logic             gie_d;
  logic             msb_d;
  logic             nmb_d;
  logic             is_maskable;

  // copies of the gating state one edge back
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_cnt <= '0;
      mask_d  <= '0;
      gie_d   <= 1'b0;
      msb_d   <= 1'b0;
      nmb_d   <= 1'b0;
    end else begin
      mask_d <= {1'b0, mask_q};
      gie_d  <= gie_q;
      msb_d  <= ms_busy;
      nmb_d  <= nmi_busy;
      if (ack_i && int_o)                                    lat_cnt <= CW'(1);
      else if (lat_cnt != '0 && lat_cnt < CW'(ENTRY_LAT))    lat_cnt <= lat_cnt + 1'b1;
      else                                                   lat_cnt <= '0;
    end
  end

  assign is_maskable = (id_o < IDW'(N_LINES));

  assert_ack_drops_int_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_i && int_o) |=> !int_o);

  assert_vec_after_lat_R7: assert property (@(posedge clk) disable iff (rst)
    (lat_cnt == CW'(ENTRY_LAT)) |=> vec_valid_o);

  assert_vec_only_after_lat_R7: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |-> ($past(lat_cnt) == CW'(ENTRY_LAT)));

  assert_vec_single_R7: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |=> !vec_valid_o);

  assert_masked_line_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (int_o && is_maskable) |-> !mask_d[id_o]);

  assert_enable_gates_R3: assert property (@(posedge clk) disable iff (rst)
    (int_o && is_maskable) |-> gie_d);

  assert_inservice_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (int_o && is_maskable) |-> (!msb_d && !nmb_d));

  assert_nmi_no_nest_R8: assert property (@(posedge clk) disable iff (rst)
    (int_o && !is_maskable) |-> !nmb_d);
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(
  .N_LINES   (N_LINES),
  .ENTRY_LAT (ENTRY_LAT),
  .IDW       (IDW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ack_i       (ack_i),
  .int_o       (int_o),
  .id_o        (id_o),
  .vec_valid_o (vec_valid_o),
  .mask_q      (mask_q),
  .gie_q       (gie_q),
  .ms_busy     (ms_busy),
  .nmi_busy    (nmi_busy)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int N   = 8;
  localparam int LAT = 5;
  localparam int IDW = $clog2(N + 1);
  localparam int AW  = $clog2(N + 3);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   irq = '0;
  logic           nmi = 1'b0;
  logic           we = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [31:0]    wdata = '0;
  logic           ack = 1'b0;
  logic           eos = 1'b0;
  logic           int_o;
  logic [IDW-1:0] id_o;
  logic           vec_valid_o;
  logic [31:0]    vec_o;

  always #5 clk = ~clk;

  prio_irq_ctrl #(.N_LINES(N), .ENTRY_LAT(LAT)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .irq_i       (irq),
    .nmi_i       (nmi),
    .cfg_we      (we),
    .cfg_addr    (addr),
    .cfg_wdata   (wdata),
    .ack_i       (ack),
    .eos_i       (eos),
    .int_o       (int_o),
    .id_o        (id_o),
    .vec_valid_o (vec_valid_o),
    .vec_o       (vec_o)
  );

  typedef struct {
    int          id;
    logic [31:0] vec;
    int          at;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] vec_of(int k);
    return 32'h4000_0100 + 32'(k) * 32'h0000_0230;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(int a, logic [31:0] d);
    we = 1'b1; addr = AW'(a); wdata = d;
    tick(1);
    we = 1'b0;
  endtask

  task automatic pulse(logic [N-1:0] lines);
    irq = lines;
    tick(1);
    irq = '0;
  endtask

  task automatic wait_int(int exp_id, string tag);
    int n = 0;
    while (!int_o && n < 20) begin
      tick(1);
      n++;
    end
    chk({tag, " int_o raised"}, int_o, 1);
    chk({tag, " id_o"}, id_o, exp_id);
  endtask

  // driver side of the scoreboard: push the expected vector, then acknowledge
  task automatic do_ack(int exp_id, string tag);
    exp_t e;
    chk({tag, " int_o before ack"}, int_o, 1);
    chk({tag, " id_o before ack"}, id_o, exp_id);
    e.id = exp_id; e.vec = vec_of(exp_id); e.at = cyc;
    q.push_back(e);
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    chk("R6 int_o low after ack", int_o, 0);
    tick(LAT);
  endtask

  task automatic do_eos();
    eos = 1'b1;
    tick(1);
    eos = 1'b0;
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (!rst && vec_valid_o) begin
      if (q.size() == 0) begin
        chk("R7 unexpected vector strobe", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk("R7 vector address", vec_o, e.vec);
        chk("R7 id during vector", id_o, e.id);
        chk("R7 entry latency", cyc - e.at, LAT + 1);
      end
    end
  end

  initial begin
    tick(3);
    chk("R10 reset int_o", int_o, 0);
    chk("R10 reset vec_valid_o", vec_valid_o, 0);
    chk("R10 reset id_o", id_o, 0);
    chk("R10 reset vec_o", vec_o, 0);
    rst = 1'b0;
    tick(1);

    // enable is 0 after reset: a request must stay silent
    pulse(N'(1 << 7));
    tick(4);
    chk("R10 enable clear after reset", int_o, 0);
    for (int k = 0; k <= N; k++) cfg(2 + k, vec_of(k));
    cfg(1, 32'h1);
    wait_int(7, "R10 mask clear after reset");
    do_ack(7, "R10");
    do_eos();
    tick(2);

    // R1, R5, R8, R9: two lines together
    pulse(N'(8'b0010_0100));
    chk("R5 int_o not yet", int_o, 0);
    tick(1);
    chk("R5 int_o after two edges", int_o, 1);
    chk("R1 lowest line wins", id_o, 2);
    do_ack(2, "R1");
    tick(3);
    chk("R8 maskable blocked in service", int_o, 0);
    do_eos();
    chk("R9 not before next edge", int_o, 0);
    tick(1);
    chk("R9 remaining request presented", int_o, 1);
    chk("R9 remaining id", id_o, 5);
    do_ack(5, "R9");
    do_eos();
    tick(3);
    chk("R6 pending cleared by ack", int_o, 0);

    // R3: global enable
    cfg(1, 32'h0);
    pulse(N'(1 << 1));
    tick(4);
    chk("R3 enable off blocks", int_o, 0);
    cfg(1, 32'h1);
    wait_int(1, "R3 held request after enable");
    do_ack(1, "R3");
    do_eos();
    tick(2);

    // R2: mask
    cfg(0, 32'h0000_0008);
    pulse(N'((1 << 3) | (1 << 6)));
    wait_int(6, "R2 masked line skipped");
    do_ack(6, "R2");
    do_eos();
    tick(4);
    chk("R2 masked line silent", int_o, 0);
    cfg(0, 32'h0);
    wait_int(3, "R2 unmasked line served");
    do_ack(3, "R2");
    do_eos();
    tick(2);

    // R4: urgent line bypasses mask and enable, edge only
    cfg(0, 32'h0000_00FF);
    cfg(1, 32'h0);
    nmi = 1'b1;
    wait_int(N, "R4 urgent bypass");
    do_ack(N, "R4");
    do_eos();
    tick(5);
    chk("R4 steady level no retrigger", int_o, 0);
    nmi = 1'b0;
    tick(2);

    // R8: preemption and nesting
    cfg(0, 32'h0);
    cfg(1, 32'h1);
    pulse(N'(1 << 4));
    wait_int(4, "R8 maskable first");
    do_ack(4, "R8");
    nmi = 1'b1;
    wait_int(N, "R8 urgent preempts");
    do_ack(N, "R8");
    nmi = 1'b0;
    pulse(N'(1));
    nmi = 1'b1;
    tick(4);
    chk("R8 urgent in service blocks all", int_o, 0);
    do_eos();
    tick(1);
    chk("R9 urgent pending after end", int_o, 1);
    chk("R1 urgent beats line 0", id_o, N);
    do_ack(N, "R9");
    nmi = 1'b0;
    do_eos();
    tick(3);
    chk("R8 outer maskable still blocks", int_o, 0);
    do_eos();
    tick(1);
    chk("R9 line 0 after outer end", int_o, 1);
    chk("R9 line 0 id", id_o, 0);
    do_ack(0, "R9");
    do_eos();
    tick(2);

    // R1: all lines at once come out in index order
    pulse('1);
    for (int k = 0; k < N; k++) begin
      wait_int(k, "R1 order");
      do_ack(k, "R1");
      do_eos();
    end
    tick(4);
    chk("R1 all served", int_o, 0);
    chk("R7 scoreboard drained", q.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule